// File: doc/BRIEF.md
# Prescaled Periodic Timebase Timer

This block produces periodic interrupt requests from the system clock. A power-of-two prescaler turns the clock into a tick, and each tick advances an 8-bit up-counter. When the counter passes from its top value back to zero, a sticky overflow flag is set. If interrupts are enabled, the flag also drives the interrupt request line.

Software sets a period by preloading the counter. There is no automatic reload, so after a wrap the counter simply keeps counting up from zero. Two byte-wide registers sit behind a plain synchronous read/write port:
- a counter register that software can read and write;
- a control/status register holding the prescaler code, the counter enable, the interrupt enable and the overflow flag.

The port has no handshake. Every access completes in the cycle it is presented, so the port never applies back-pressure. Read data is combinational from the address.

Top module: `ptb_timebase`

## Requirements
- R1: After reset, both registers read 00h, the interrupt line is low and the prescaler phase is zero.
- R2: While enabled, the counter increments by exactly one on each prescaler tick and wraps from FFh to 00h. It never takes any other step unless software writes it.
- R3: Prescaler code n (control bits 2:0) divides by 2^(n+1), from 2 (code 0) up to 256 (code 7). The prescaler is a divider that is cleared while counting is disabled. The first increment after enabling therefore lands exactly 2^(n+1) cycles after the write that set the enable.
- R4: Setting the counter enable (control bit 3) starts counting from the value the counter already holds. While the enable is clear, the counter holds its value and no overflow occurs.
- R5: Each FFh-to-00h wrap sets the overflow flag (control bit 5), taking effect on the same edge as the wrap.
- R6: The interrupt request is high exactly when the overflow flag and the interrupt enable (control bit 4) are both set.
- R7: A read strobe on the control/status register while the flag is set clears the flag on the next edge. A wrap in that same cycle keeps the flag set.
- R8: A write to the counter takes effect on the next edge, whether or not counting is enabled. If a tick falls in the same cycle, the written value is loaded and no increment happens.
- R9: Control bits 7 and 6 always read 0. The overflow flag cannot be set or cleared by a write. A write of 1Fh selects divide-by-256 with both enables set.
- R10: Address 0 selects the counter and address 1 selects control/status. Read data always shows the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; needed only for clear-on-read of the flag |
| reg_addr | input | 1 | Register select: 0 counter, 1 control/status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Contents of the addressed register |
| irq | output | 1 | Interrupt request (flag AND interrupt enable) |

## Verification
Four directed patterns each separate one behaviour:
- A counter preload of E0h with control 1Fh tells the divide-by-256 timing apart from off-by-one periods: the interrupt must rise after exactly 8192 cycles and not one cycle earlier.
- A preload of FEh at divide-by-2 checks the shortest period.
- Back-to-back counter writes at divide-by-2 land on tick cycles and expose any increment that leaks past a load.
- Writes to the control register while disabled show whether the flag can be written and whether bits 7:6 read 0.

Random traffic then mixes several kinds of access, all compared every cycle against a model built from the requirements:
- preloads biased toward F0h–FFh, so wraps happen often;
- random control codes for the four fastest prescaler settings;
- read-to-clear strobes that land near wraps;
- enable toggles, which exercise the prescaler phase restart.

// File: rtl/ptb_pkg.sv
`timescale 1ns/1ps
package ptb_pkg;
  // register width and prescaler code width
  localparam int REG_W  = 8;
  localparam int PSEL_W = 3;
  // register addresses
  localparam logic ADDR_COUNT = 1'b0;
  localparam logic ADDR_CTRL  = 1'b1;
  // control/status bit positions
  localparam int BIT_FLAG = 5;
  localparam int BIT_IE   = 4;
  localparam int BIT_CEN  = 3;
endpackage

// File: rtl/ptb_prescaler.sv
`timescale 1ns/1ps
module ptb_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = 1 << SEL_W;
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] tap;

  // free-running divider, held at zero while counting is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (!run) div_q <= '0;
    else           div_q <= div_q + ONE;
  end

  // tap g fires once every 2^(g+1) cycles
  for (genvar g = 0; g < DIV_W; g++) begin : g_tap
    assign tap[g] = &div_q[g:0];
  end

  assign tick = run & tap[sel];
endmodule

// File: rtl/ptb_upcounter.sv
`timescale 1ns/1ps
module ptb_upcounter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  // a load takes priority over a step in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (step) value <= value + ONE;
  end

  assign wrap = step & ~load & (value == TOP);
endmodule

// File: rtl/ptb_ctrl.sv
`timescale 1ns/1ps
module ptb_ctrl
  import ptb_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int SEL_W  = PSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wrap,
  output logic [SEL_W-1:0]  psel,
  output logic              cen,
  output logic              ie,
  output logic              flag,
  output logic              irq,
  output logic [DATA_W-1:0] status
);
  // writable fields; the flag is not among them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel <= '0;
      cen  <= 1'b0;
      ie   <= 1'b0;
    end else if (wr) begin
      psel <= wdata[SEL_W-1:0];
      cen  <= wdata[BIT_CEN];
      ie   <= wdata[BIT_IE];
    end
  end

  // sticky flag: a wrap sets it, and wins over a clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag <= 1'b0;
    else if (wrap)       flag <= 1'b1;
    else if (rd && flag) flag <= 1'b0;
  end

  assign irq = flag & ie;

  always_comb begin
    status              = '0;
    status[SEL_W-1:0]   = psel;
    status[BIT_CEN]     = cen;
    status[BIT_IE]      = ie;
    status[BIT_FLAG]    = flag;
  end
endmodule

// File: rtl/ptb_timebase.sv
`timescale 1ns/1ps
module ptb_timebase
  import ptb_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int SEL_W  = PSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic              wr_count, wr_ctrl, rd_ctrl;
  logic              presc_tick, wrap;
  logic [DATA_W-1:0] count_q, status;
  logic [SEL_W-1:0]  psel_q;
  logic              cen_q, ie_q, flag_q;

  assign wr_count = reg_wr & (reg_addr == ADDR_COUNT);
  assign wr_ctrl  = reg_wr & (reg_addr == ADDR_CTRL);
  assign rd_ctrl  = reg_rd & (reg_addr == ADDR_CTRL);

  ptb_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (cen_q),
    .sel   (psel_q),
    .tick  (presc_tick)
  );

  ptb_upcounter #(.W(DATA_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_count),
    .load_val (reg_wdata),
    .step     (presc_tick),
    .value    (count_q),
    .wrap     (wrap)
  );

  ptb_ctrl #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_ctrl),
    .rd     (rd_ctrl),
    .wdata  (reg_wdata),
    .wrap   (wrap),
    .psel   (psel_q),
    .cen    (cen_q),
    .ie     (ie_q),
    .flag   (flag_q),
    .irq    (irq),
    .status (status)
  );

  always_comb begin
    if (reg_addr == ADDR_CTRL) reg_rdata = status;
    else                       reg_rdata = count_q;
  end
endmodule

// File: rtl/ptb_timebase_chk.sv
`timescale 1ns/1ps
module ptb_timebase_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] count_q,
  input logic              run,
  input logic              tick,
  input logic              flag_q,
  input logic              ie,
  input logic              irq
);
  localparam logic [DATA_W-1:0] TOP = '1;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic cnt_write;
  assign cnt_write = reg_wr && (reg_addr == 1'b0);

  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_write) |=> (count_q == $past(count_q)));

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_write |=> (count_q == $past(reg_wdata)));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_write) |=> ((count_q == $past(count_q)) || (count_q == $past(count_q) + ONE)));

  assert_flag_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (($past(count_q) == TOP) && (count_q == '0)));

  assert_no_tick_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);

  assert_flag_not_writable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && !flag_q && !(run && tick && count_q == TOP)) |=> !flag_q);
endmodule

bind ptb_timebase ptb_timebase_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .count_q   (count_q),
  .run       (cen_q),
  .tick      (presc_tick),
  .flag_q    (flag_q),
  .ie        (ie_q),
  .irq       (irq)
);

// File: tb/test_ptb_timebase.sv
`timescale 1ns/1ps
module test_ptb_timebase;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  ptb_timebase i_ptb_timebase (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // reference model built from the requirements
  logic [7:0] m_cnt, m_div;
  logic [2:0] m_psel;
  logic       m_cen, m_ie, m_flag;

  function automatic logic m_tick(input logic [7:0] d, input logic [2:0] s, input logic en);
    logic [7:0] mask;
    mask = 8'((16'd2 << s) - 16'd1);  // R3: divide by 2^(s+1)
    return en && ((d & mask) == mask);
  endfunction

  function automatic logic [7:0] m_rdata(input logic a);
    if (a) return {2'b00, m_flag, m_ie, m_cen, m_psel};  // R9 layout
    else   return m_cnt;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 8'h00; m_div = 8'h00; m_psel = 3'd0;
      m_cen = 1'b0; m_ie = 1'b0; m_flag = 1'b0;
    end else begin
      logic t, cvw, cw, wrp;
      t   = m_tick(m_div, m_psel, m_cen);
      cvw = reg_wr && !reg_addr;
      cw  = reg_wr && reg_addr;
      wrp = t && (m_cnt == 8'hFF) && !cvw;
      m_div = m_cen ? m_div + 8'd1 : 8'd0;
      if (cvw)    m_cnt = reg_wdata;
      else if (t) m_cnt = m_cnt + 8'd1;
      if (wrp) m_flag = 1'b1;
      else if (reg_rd && reg_addr && m_flag) m_flag = 1'b0;
      if (cw) begin
        m_psel = reg_wdata[2:0];
        m_cen  = reg_wdata[3];
        m_ie   = reg_wdata[4];
      end
    end
  end

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s at %0t: actual %02h expected %02h", req, $time, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare before the edge, return at next negedge
  task automatic cyc(input logic wr, input logic rd, input logic a, input logic [7:0] d);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    #2;
    chk8(a ? "R9" : "R2", reg_rdata, m_rdata(a));
    chk8("R6", {7'd0, irq}, {7'd0, m_flag & m_ie});
    @(negedge clk);
  endtask

  // idle cycle with a literal expectation as well
  task automatic expect_at(input string req, input logic a, input logic [7:0] ed, input logic ei);
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = a; reg_wdata = 8'h00;
    #2;
    chk8(req, reg_rdata, ed);
    chk8(req, {7'd0, irq}, {7'd0, ei});
    @(negedge clk);
  endtask

  initial begin
    #3000000;
    n_checks++; n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 address map
    expect_at("R1", 1'b0, 8'h00, 1'b0);
    expect_at("R1", 1'b1, 8'h00, 1'b0);

    // R3/R5: preload E0h, control 1Fh: interrupt after exactly 32*256 cycles
    cyc(1'b1, 1'b0, 1'b0, 8'hE0);
    expect_at("R10", 1'b0, 8'hE0, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 8'h1F);
    repeat (8191) cyc(1'b0, 1'b0, 1'b0, 8'h00);
    expect_at("R3", 1'b0, 8'hFF, 1'b0);
    expect_at("R5", 1'b0, 8'h00, 1'b1);
    expect_at("R9", 1'b1, 8'h3F, 1'b1);

    // R7: disable, then a read clears the flag
    cyc(1'b1, 1'b0, 1'b1, 8'h10);
    expect_at("R7", 1'b1, 8'h30, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, 8'h00);
    expect_at("R7", 1'b1, 8'h10, 1'b0);

    // R4: disabled counter holds a written value
    cyc(1'b1, 1'b0, 1'b0, 8'h10);
    repeat (40) cyc(1'b0, 1'b0, 1'b0, 8'h00);
    expect_at("R4", 1'b0, 8'h10, 1'b0);

    // R9: flag not writable, bits 7:6 read zero
    cyc(1'b1, 1'b0, 1'b1, 8'hE7);
    expect_at("R9", 1'b1, 8'h07, 1'b0);

    // R3 shortest period: preload FEh, divide-by-2, interrupts on
    cyc(1'b1, 1'b0, 1'b0, 8'hFE);
    cyc(1'b1, 1'b0, 1'b1, 8'h18);
    cyc(1'b0, 1'b0, 1'b0, 8'h00);
    expect_at("R3", 1'b0, 8'hFE, 1'b0);
    expect_at("R3", 1'b0, 8'hFF, 1'b0);
    expect_at("R4", 1'b0, 8'hFF, 1'b0);
    expect_at("R5", 1'b0, 8'h00, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, 8'h00);

    // R8: writes collide with ticks, the written value wins
    repeat (4) cyc(1'b1, 1'b0, 1'b0, 8'h55);
    expect_at("R8", 1'b0, 8'h55, 1'b0);

    // random traffic against the model
    for (int i = 0; i < 20000; i++) begin
      int unsigned p;
      logic [7:0] d;
      p = $urandom_range(99);
      d = 8'($urandom);
      if (p < 6)       cyc(1'b1, 1'b0, 1'b0, 8'hF0 | {4'h0, d[3:0]});
      else if (p < 9)  cyc(1'b1, 1'b0, 1'b0, d);
      else if (p < 14) begin
        d[2:0] = 3'($urandom_range(3));
        d[3]   = ($urandom_range(9) != 0);
        cyc(1'b1, 1'b0, 1'b1, d);
      end
      else if (p < 24) cyc(1'b0, 1'b1, 1'b1, 8'h00);
      else if (p < 27) cyc(1'b0, 1'b1, 1'b0, 8'h00);
      else             cyc(1'b0, 1'b0, d[7], d);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule